// File: doc/BRIEF.md
# Video Encoder Power and Load-Sense Control

This block is the register-mapped control unit of a video output encoder. A simple single-cycle register bus reaches two registers. The power register holds a three-bit power mode, an active-low soft reset bit and an output-format select. The sense register starts and ends a load-sense cycle and reports which DAC outputs see a load. The block turns the power mode into registered enables for the composite DAC, the S-Video DAC pair, the general core circuitry and the buffered clock outputs. The enables and the format select drive the encoder datapath and the analog section.

A soft reset is requested by writing the reset bit low. It clears all block state except the reset bit, and it drives a level reset into the rest of the encoder. The serial interface that issues the register accesses sits outside this block and is not affected. When the format bit is 0 the three DACs carry luma, chroma and composite video. When it is 1 they carry red, green and blue, and a separate composite-sync driver is enabled.

Load sensing uses the analog comparators outside the block, whose results arrive here as three digital bits. Software starts a sense cycle by writing the start bit to 1 and ends it by writing 0. The status bits capture the comparators at that point, but only if the power mode was the all-on mode for the whole sense cycle.

Top module: `vid_pwr_ctl`

## Requirements
- R1: After power-on reset the power register reads 0x0D (mode 101, reset bit 1, format 0). The sense register reads 0x00. `det_valid`, `soft_rst` and `out_rgb` are 0, and all four enables are 0.
- R2: The power register is at address 0x0E. Bits 2:0 are the mode, bit 3 is the reset bit and bit 4 is the format select. Outside soft reset, a write stores all five bits. Bits above 4 read 0, and any address other than 0x0E and 0x10 reads 0.
- R3: The enables follow the mode one clock after the register takes it. The order is cvbs/svid/core/clk. Mode 000 gives 0111, 001 gives 0001, 010 gives 1011, 011 gives 1111 and any 1xx gives 0000.
- R4: Writing the power register with bit 3 = 0 puts the block in soft reset. The register then reads 0x05 and `soft_rst` is 1. One clock later the sense state, status and `det_valid` are clear. While in soft reset, writes to the sense register are ignored. A write with bit 3 = 1 leaves soft reset, but mode and format stay at 101 and 0.
- R5: `out_rgb` equals the format bit. `csync_en` is 1 exactly when, one clock earlier, the format bit was 1, the core enable decoded to 1 and soft reset was off.
- R6: The sense register is at address 0x10. Writing it with bit 0 = 1 sets `sense_active` at that clock edge. Writing bit 0 = 0 clears it.
- R7: Ending a sense cycle latches comparators y, c and cvbs into read bits 3, 2 and 1 of the sense register, and sets `det_valid`. This happens only if the mode was 011 at every clock of the cycle. `det_valid` stays set until a reset.
- R8: If the mode left 011 at any clock of the sense cycle, ending it leaves the status bits and `det_valid` unchanged.
- R9: Bit 0 of the sense register reads 0. Write data in bits 3:1 of the sense register has no effect on the status.
- R10: While the reset bit is 0, all four enables and `csync_en` are 0 from the next clock onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| cmp_y | input | 1 | Luma output load comparator |
| cmp_c | input | 1 | Chroma output load comparator |
| cmp_cvbs | input | 1 | Composite output load comparator |
| dac_cvbs_en | output | 1 | Composite DAC enable |
| dac_svid_en | output | 1 | S-Video DAC pair enable |
| core_en | output | 1 | General circuitry enable |
| clkbuf_en | output | 1 | Buffered clock output enable |
| out_rgb | output | 1 | DACs carry RGB instead of Y/C/CVBS |
| csync_en | output | 1 | Composite sync driver enable |
| soft_rst | output | 1 | Soft reset level to the rest of the encoder |
| sense_active | output | 1 | A load-sense cycle is in progress |
| det_valid | output | 1 | Status bits hold a valid sense result |

## Verification
The bench builds the block with its default eight-bit address and data widths, so the registers sit at 0x0E and 0x10. Those widths let the bench probe the unused neighbour addresses 0x0F and 0x11 and the top of the map at 0xFF. Random data in the three reserved upper bits reaches the power register as well. Random modes, including every 1xx pattern, test the enable decode. Directed sense cycles cover an excursion out of mode 011, a cycle started outside 011 and a cycle started during soft reset.

// File: rtl/vpd_pkg.sv
package vpd_pkg;

  localparam int MODE_W = 3;

  typedef struct packed {
    logic cvbs;
    logic svid;
    logic core;
    logic clk;
  } pwr_en_t;

  localparam logic [MODE_W-1:0] MODE_ALL_ON = 3'b011;
  localparam logic [MODE_W-1:0] MODE_RESET  = 3'b101;

  // Map a power mode to the group enables it leaves running.
  function automatic pwr_en_t pwr_decode(input logic [MODE_W-1:0] m);
    pwr_en_t e;
    casez (m)
      3'b000:  e = '{cvbs: 1'b0, svid: 1'b1, core: 1'b1, clk: 1'b1};
      3'b001:  e = '{cvbs: 1'b0, svid: 1'b0, core: 1'b0, clk: 1'b1};
      3'b010:  e = '{cvbs: 1'b1, svid: 1'b0, core: 1'b1, clk: 1'b1};
      3'b011:  e = '{cvbs: 1'b1, svid: 1'b1, core: 1'b1, clk: 1'b1};
      default: e = '0;
    endcase
    return e;
  endfunction

endpackage

// File: rtl/vpd_regs.sv
module vpd_regs
  import vpd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pmr_wr,
  input  logic [4:0]        wdata,
  output logic [MODE_W-1:0] pwr_mode,
  output logic              rst_bit,
  output logic              rgb_sel
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr_mode <= MODE_RESET;
      rst_bit  <= 1'b1;
      rgb_sel  <= 1'b0;
    end else if (pmr_wr) begin
      rst_bit <= wdata[3];
      if (rst_bit && wdata[3]) begin
        pwr_mode <= wdata[MODE_W-1:0];
        rgb_sel  <= wdata[4];
      end else begin
        pwr_mode <= MODE_RESET;
        rgb_sel  <= 1'b0;
      end
    end else if (!rst_bit) begin
      pwr_mode <= MODE_RESET;
      rgb_sel  <= 1'b0;
    end
  end

endmodule

// File: rtl/vpd_sense.sv
module vpd_sense
  import vpd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_clr,
  input  logic              det_wr,
  input  logic              start_bit,
  input  logic [MODE_W-1:0] pwr_mode,
  input  logic [2:0]        cmp_in,
  output logic              sense_q,
  output logic [2:0]        status,
  output logic              valid,
  output logic              latch_ev
);

  logic mode_ok;
  logic ok_q;
  logic start_ev;
  logic stop_ev;

  assign mode_ok  = (pwr_mode == MODE_ALL_ON);
  assign start_ev = det_wr && !soft_clr && start_bit && !sense_q;
  assign stop_ev  = det_wr && !soft_clr && !start_bit && sense_q;
  assign latch_ev = stop_ev && ok_q && mode_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sense_q <= 1'b0;
      ok_q    <= 1'b0;
      status  <= '0;
      valid   <= 1'b0;
    end else if (soft_clr) begin
      sense_q <= 1'b0;
      ok_q    <= 1'b0;
      status  <= '0;
      valid   <= 1'b0;
    end else begin
      if (start_ev) begin
        sense_q <= 1'b1;
        ok_q    <= mode_ok;
      end else if (stop_ev) begin
        sense_q <= 1'b0;
        ok_q    <= 1'b0;
      end else if (sense_q && !mode_ok) begin
        ok_q <= 1'b0;
      end
      if (latch_ev) begin
        status <= cmp_in;
        valid  <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/vpd_pwr_decode.sv
module vpd_pwr_decode
  import vpd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] pwr_mode,
  input  logic              rst_bit,
  input  logic              rgb_sel,
  output pwr_en_t           en_q,
  output logic              csync_q
);

  pwr_en_t en_d;

  assign en_d = rst_bit ? pwr_decode(pwr_mode) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      csync_q <= 1'b0;
    end else begin
      en_q    <= en_d;
      csync_q <= rgb_sel && en_d.core;
    end
  end

endmodule

// File: rtl/vid_pwr_ctl.sv
module vid_pwr_ctl
  import vpd_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] PMR_ADDR = 8'h0E,
  parameter logic [ADDR_W-1:0] DET_ADDR = 8'h10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              cmp_y,
  input  logic              cmp_c,
  input  logic              cmp_cvbs,
  output logic              dac_cvbs_en,
  output logic              dac_svid_en,
  output logic              core_en,
  output logic              clkbuf_en,
  output logic              out_rgb,
  output logic              csync_en,
  output logic              soft_rst,
  output logic              sense_active,
  output logic              det_valid
);

  localparam int PMR_BITS = MODE_W + 2;

  logic              pmr_wr;
  logic              det_wr;
  logic [MODE_W-1:0] pwr_mode;
  logic              rst_bit;
  logic              rgb_sel;
  logic [2:0]        det_status;
  logic              latch_ev;
  pwr_en_t           en_q;
  logic              unused_wbits;

  assign pmr_wr       = bus_wr && (bus_addr == PMR_ADDR);
  assign det_wr       = bus_wr && (bus_addr == DET_ADDR);
  assign unused_wbits = ^bus_wdata[DATA_W-1:PMR_BITS];

  vpd_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .pmr_wr   (pmr_wr),
    .wdata    (bus_wdata[PMR_BITS-1:0]),
    .pwr_mode (pwr_mode),
    .rst_bit  (rst_bit),
    .rgb_sel  (rgb_sel)
  );

  vpd_sense u_sense (
    .clk       (clk),
    .rst_n     (rst_n),
    .soft_clr  (!rst_bit),
    .det_wr    (det_wr),
    .start_bit (bus_wdata[0]),
    .pwr_mode  (pwr_mode),
    .cmp_in    ({cmp_y, cmp_c, cmp_cvbs}),
    .sense_q   (sense_active),
    .status    (det_status),
    .valid     (det_valid),
    .latch_ev  (latch_ev)
  );

  vpd_pwr_decode u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwr_mode (pwr_mode),
    .rst_bit  (rst_bit),
    .rgb_sel  (rgb_sel),
    .en_q     (en_q),
    .csync_q  (csync_en)
  );

  assign dac_cvbs_en = en_q.cvbs;
  assign dac_svid_en = en_q.svid;
  assign core_en     = en_q.core;
  assign clkbuf_en   = en_q.clk;
  assign out_rgb     = rgb_sel;
  assign soft_rst    = !rst_bit;

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == PMR_ADDR) begin
      bus_rdata[PMR_BITS-1:0] = {rgb_sel, rst_bit, pwr_mode};
    end else if (bus_addr == DET_ADDR) begin
      bus_rdata[3:1] = det_status;
    end
  end

endmodule

// File: rtl/vpd_chk.sv
module vpd_chk
  import vpd_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [MODE_W-1:0] pwr_mode,
  input logic [2:0]        det_status,
  input logic              latch_ev,
  input logic              dac_cvbs_en,
  input logic              dac_svid_en,
  input logic              core_en,
  input logic              clkbuf_en,
  input logic              out_rgb,
  input logic              csync_en,
  input logic              soft_rst,
  input logic              sense_active,
  input logic              det_valid
);

  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata >> 5) == '0);

  p_enables_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> !(dac_cvbs_en || dac_svid_en || core_en || clkbuf_en || csync_en));

  p_sense_cleared_r4: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> !sense_active && !det_valid);

  p_csync_fmt_r5: assert property (@(posedge clk) disable iff (!rst_n)
    csync_en |-> $past(out_rgb));

  p_latch_mode_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(det_valid) |-> $past(pwr_mode) == MODE_ALL_ON && $past(sense_active));

  p_valid_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    det_valid && !soft_rst |=> det_valid);

  p_status_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_ev && !soft_rst |=> $stable(det_status));

endmodule

bind vid_pwr_ctl vpd_chk #(.DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_rdata    (bus_rdata),
  .pwr_mode     (pwr_mode),
  .det_status   (det_status),
  .latch_ev     (latch_ev),
  .dac_cvbs_en  (dac_cvbs_en),
  .dac_svid_en  (dac_svid_en),
  .core_en      (core_en),
  .clkbuf_en    (clkbuf_en),
  .out_rgb      (out_rgb),
  .csync_en     (csync_en),
  .soft_rst     (soft_rst),
  .sense_active (sense_active),
  .det_valid    (det_valid)
);

// File: tb/vid_pwr_ctl_tb_top.sv
`timescale 1ns/1ps
module vid_pwr_ctl_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_addr = 8'h00;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       cmp_y = 1'b0, cmp_c = 1'b0, cmp_cvbs = 1'b0;
  logic       dac_cvbs_en, dac_svid_en, core_en, clkbuf_en;
  logic       out_rgb, csync_en, soft_rst, sense_active, det_valid;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;

  always #5 clk = ~clk;

  vid_pwr_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cmp_y(cmp_y), .cmp_c(cmp_c), .cmp_cvbs(cmp_cvbs),
    .dac_cvbs_en(dac_cvbs_en), .dac_svid_en(dac_svid_en),
    .core_en(core_en), .clkbuf_en(clkbuf_en), .out_rgb(out_rgb),
    .csync_en(csync_en), .soft_rst(soft_rst),
    .sense_active(sense_active), .det_valid(det_valid)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  // Expected enables, order cvbs/svid/core/clk.
  function automatic logic [3:0] exp_en(input logic [2:0] m);
    logic cv, sv, co, ck;
    ck = !m[2];
    cv = ck && m[1];
    sv = ck && (m[1] == m[0]);
    co = ck && (m[1] || !m[0]);
    return {cv, sv, co, ck};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  function automatic logic [3:0] en_now();
    return {dac_cvbs_en, dac_svid_en, core_en, clkbuf_en};
  endfunction

  task automatic sense_cycle(input logic [2:0] cmp);
    wr(8'h10, 8'h01);
    {cmp_y, cmp_c, cmp_cvbs} = cmp;
    wr(8'h10, 8'h00);
  endtask

  initial begin
    logic [7:0] d;
    logic [2:0] m;
    logic       f;
    logic [2:0] cv;
    logic [3:0] last_status;
    void'($urandom(32'h1234_abcd));

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(8'h0E, d); chk("R1 pmr reset", d, 8'h0D);
    rd(8'h10, d); chk("R1 det reset", d, 8'h00);
    chk("R1 enables", en_now(), 4'b0000);
    chk("R1 flags", {det_valid, soft_rst, out_rgb, csync_en, sense_active}, 5'b0);

    // R2 unmapped addresses
    rd(8'h0F, d); chk("R2 addr 0F", d, 8'h00);
    rd(8'h11, d); chk("R2 addr 11", d, 8'h00);
    rd(8'hFF, d); chk("R2 addr FF", d, 8'h00);

    // R2 R3 R5 random modes, reserved bits random
    for (int i = 0; i < 40; i++) begin
      m = 3'($urandom % 8);
      f = 1'($urandom % 2);
      wr(8'h0E, {3'($urandom % 8), f, 1'b1, m});
      rd(8'h0E, d);
      chk("R2 pmr readback", d, {3'b000, f, 1'b1, m});
      chk("R5 out_rgb", out_rgb, f);
      chk("R3 enables", en_now(), exp_en(m));
      chk("R5 csync", csync_en, f & exp_en(m)[1]);
    end

    // R6 R7 directed latch
    wr(8'h0E, 8'h0B);
    wr(8'h10, 8'h01);
    chk("R6 sense on", sense_active, 1'b1);
    {cmp_y, cmp_c, cmp_cvbs} = 3'b101;
    wr(8'h10, 8'h00);
    chk("R6 sense off", sense_active, 1'b0);
    rd(8'h10, d); chk("R7 status", d, 8'h0A);
    chk("R7 valid", det_valid, 1'b1);

    // R8 excursion out of mode 011
    wr(8'h10, 8'h01);
    wr(8'h0E, 8'h09);
    wr(8'h0E, 8'h0B);
    {cmp_y, cmp_c, cmp_cvbs} = 3'b010;
    wr(8'h10, 8'h00);
    rd(8'h10, d); chk("R8 excursion", d, 8'h0A);

    // R8 started outside 011
    wr(8'h0E, 8'h08);
    sense_cycle(3'b011);
    rd(8'h10, d); chk("R8 wrong mode", d, 8'h0A);
    chk("R8 valid kept", det_valid, 1'b1);

    // R9 writes to status bits
    wr(8'h10, 8'h0E);
    rd(8'h10, d); chk("R9 status ignore", d, 8'h0A);

    // R7 random sense results
    wr(8'h0E, 8'h0B);
    last_status = 4'hA;
    for (int i = 0; i < 20; i++) begin
      cv = 3'($urandom % 8);
      sense_cycle(cv);
      rd(8'h10, d);
      chk("R7 random latch", d, {4'h0, cv, 1'b0});
      chk("R9 bit0 reads 0", d[0], 1'b0);
      last_status = {cv, 1'b0};
    end

    // R4 R10 soft reset
    wr(8'h0E, 8'h13);
    rd(8'h0E, d); chk("R4 pmr in reset", d, 8'h05);
    chk("R4 soft_rst", soft_rst, 1'b1);
    @(negedge clk);
    chk("R10 enables off", {en_now(), csync_en}, 5'b0);
    chk("R4 valid cleared", det_valid, 1'b0);
    rd(8'h10, d); chk("R4 status cleared", d, 8'h00);
    wr(8'h10, 8'h01);
    chk("R4 sense ignored", sense_active, 1'b0);
    wr(8'h0E, 8'h1B);
    rd(8'h0E, d); chk("R4 release defaults", d, 8'h0D);
    chk("R4 soft_rst off", soft_rst, 1'b0);
    wr(8'h0E, 8'h1B);
    rd(8'h0E, d); chk("R2 after release", d, 8'h1B);
    @(negedge clk);
    chk("R3 all on", en_now(), 4'b1111);
    chk("R5 csync on", csync_en, 1'b1);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule